// File: doc/BRIEF.md
# Masked SYNC Pattern Matcher

This block hunts for the scrambled SYNC preamble in a despread DSSS bit stream. Every accepted bit is shifted into a 60-bit history window, and the window is compared position by position with a stored 60-bit target. A mask limits the comparison to the 48 newest positions. The 12 oldest positions are padding that is never scored, so the bits that arrived most recently always take part in the comparison.

The number of agreeing scored positions is the score. A search starts with a start pulse, which clears the window. The search ends in one of two ways. It ends with a match pulse when the score reaches the programmed threshold. It ends with a timeout pulse when a programmed number of bits, scaled by 32, has arrived without a match. The threshold and the timeout are 8-bit fields that the surrounding logic supplies as live inputs.

Top module: `dsss_sync_matcher`

## Requirements
- R1: After reset, match_o and timeout_o are 0, score_o is 0, and the block is idle. Valid bits received before the first start pulse change nothing.
- R2: A start pulse clears the window to all zeros, clears the bit count and sets score_o to 0 in the next cycle. A bit offered in the same cycle as start is discarded. A start pulse during a search restarts that search.
- R3: Each accepted bit enters at the newest window position, and every older bit moves one position toward the oldest end. Listed from oldest to newest, the target is 1110 11101100 11101000 10100100 11111001 10010101 10001100 00100101.
- R4: The score is the number of the 48 newest window positions that equal the target bit in the same position. The 12 oldest positions never count. score_o shows the new score in the cycle after each accepted bit.
- R5: If the updated score is greater than or equal to thresh_i, match_o pulses for exactly one cycle, in the same cycle the new score appears, and the search stops. A threshold of 0 matches on the first bit.
- R6: If tmo_i is nonzero and the accepted bit brings the count since start to tmo_i×32 without a match, timeout_o pulses for one cycle and the search stops. When both conditions occur on the same bit, only match_o pulses.
- R7: When tmo_i is 0, there is no bit limit and the search runs until it matches or restarts.
- R8: After a match or timeout, until the next start pulse, incoming bits leave score_o unchanged and produce no pulse.
- R9: A cycle with bit_vld_i low during a search changes neither the window, nor the count, nor score_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new search (clears the window) |
| bit_vld_i | input | 1 | bit_i carries a new despread bit |
| bit_i | input | 1 | Despread bit |
| thresh_i | input | 8 | Score needed for a match |
| tmo_i | input | 8 | Search limit in units of 32 bits; 0 disables |
| match_o | output | 1 | One-cycle pulse: pattern found |
| timeout_o | output | 1 | One-cycle pulse: search limit reached |
| score_o | output | 6 | Latest masked agreement count |

## Verification
The bench builds the block with its default parameters: a 60-bit window, 12 padding positions and a timeout shift of 5.

Timeout values of 1 and 2 put the scaled limits of 32 and 64 bits within a short run. With these limits the bench can place a full target exactly on the 64th bit, so a match and a timeout fall due on the same bit. Thresholds of 0, 48 and 60 cover three cases: an immediate match, a match that needs every scored position, and a score that can never be reached, which lets the bench watch both the timeout and the unlimited search.

// File: rtl/sync_match_pkg.sv
package sync_match_pkg;
    localparam int DEF_WIN_W     = 60;
    localparam int DEF_PAD_W     = 12;
    localparam int DEF_THR_W     = 8;
    localparam int DEF_TMO_W     = 8;
    localparam int DEF_TMO_SHIFT = 5;

    // Bit 0 is the newest window position; the literal reads oldest first.
    localparam logic [DEF_WIN_W-1:0] SYNC_TARGET =
        60'b1110_11101100_11101000_10100100_11111001_10010101_10001100_00100101;
endpackage

// File: rtl/sync_masked_score.sv
module sync_masked_score #(
    parameter int WIN_W   = 60,
    parameter int PAD_W   = 12,
    parameter int SCORE_W = 6,
    parameter logic [WIN_W-1:0] TARGET = '0
) (
    input  logic [WIN_W-1:0]   hist_i,
    output logic [SCORE_W-1:0] score_o
);
    localparam int SCORED_W = WIN_W - PAD_W;

    logic [WIN_W-1:0] agree;

    for (genvar p = 0; p < WIN_W; p++) begin : g_pos
        if (p < SCORED_W) begin : g_scored
            assign agree[p] = ~(hist_i[p] ^ TARGET[p]);
        end else begin : g_pad
            assign agree[p] = 1'b0;
        end
    end

    always_comb begin
        score_o = '0;
        for (int p = 0; p < WIN_W; p++) begin
            score_o = score_o + SCORE_W'(agree[p]);
        end
    end
endmodule

// File: rtl/sync_bit_limit.sv
module sync_bit_limit #(
    parameter int TMO_W     = 8,
    parameter int TMO_SHIFT = 5,
    parameter int CNT_W     = TMO_W + TMO_SHIFT
) (
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] limit;

    assign limit = {tmo_i, {TMO_SHIFT{1'b0}}};
    assign hit_o = (tmo_i != '0) && (cnt_next_i == limit);
endmodule

// File: rtl/dsss_sync_matcher.sv
module dsss_sync_matcher
    import sync_match_pkg::*;
#(
    parameter int WIN_W     = DEF_WIN_W,
    parameter int PAD_W     = DEF_PAD_W,
    parameter int THR_W     = DEF_THR_W,
    parameter int TMO_W     = DEF_TMO_W,
    parameter int TMO_SHIFT = DEF_TMO_SHIFT,
    parameter logic [WIN_W-1:0] TARGET = WIN_W'(SYNC_TARGET),
    localparam int SCORE_W  = $clog2(WIN_W - PAD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               bit_vld_i,
    input  logic               bit_i,
    input  logic [THR_W-1:0]   thresh_i,
    input  logic [TMO_W-1:0]   tmo_i,
    output logic               match_o,
    output logic               timeout_o,
    output logic [SCORE_W-1:0] score_o
);
    localparam int CNT_W = TMO_W + TMO_SHIFT;
    localparam int CMP_W = THR_W + SCORE_W;

    typedef struct packed {
        logic [WIN_W-1:0]   hist;
        logic [CNT_W-1:0]   cnt;
        logic [SCORE_W-1:0] score;
        logic               active;
        logic               match;
        logic               tmo;
    } srch_state_t;

    srch_state_t st_d, st_q;

    logic [WIN_W-1:0]   hist_shift;
    logic [CNT_W-1:0]   cnt_inc;
    logic [SCORE_W-1:0] score_new;
    logic               limit_hit;

    assign hist_shift = {st_q.hist[WIN_W-2:0], bit_i};
    assign cnt_inc    = st_q.cnt + CNT_W'(1);

    sync_masked_score #(
        .WIN_W  (WIN_W),
        .PAD_W  (PAD_W),
        .SCORE_W(SCORE_W),
        .TARGET (TARGET)
    ) u_score (
        .hist_i (hist_shift),
        .score_o(score_new)
    );

    sync_bit_limit #(
        .TMO_W    (TMO_W),
        .TMO_SHIFT(TMO_SHIFT),
        .CNT_W    (CNT_W)
    ) u_limit (
        .cnt_next_i(cnt_inc),
        .tmo_i     (tmo_i),
        .hit_o     (limit_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        st_d.tmo   = 1'b0;
        if (start_i) begin
            st_d.hist   = '0;
            st_d.cnt    = '0;
            st_d.score  = '0;
            st_d.active = 1'b1;
        end else if (st_q.active && bit_vld_i) begin
            st_d.hist  = hist_shift;
            st_d.cnt   = cnt_inc;
            st_d.score = score_new;
            if (CMP_W'(score_new) >= CMP_W'(thresh_i)) begin
                st_d.match  = 1'b1;
                st_d.active = 1'b0;
            end else if (limit_hit) begin
                st_d.tmo    = 1'b1;
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o   = st_q.match;
    assign timeout_o = st_q.tmo;
    assign score_o   = st_q.score;
endmodule

// File: rtl/sync_matcher_chk.sv
module sync_matcher_chk #(
    parameter int SCORE_W  = 6,
    parameter int THR_W    = 8,
    parameter int SCORED_W = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [THR_W-1:0]   thresh_i,
    input logic               match_o,
    input logic               timeout_o,
    input logic [SCORE_W-1:0] score_o,
    input logic               active_q
);
    // R5 R6: the two outcomes never pulse together
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && timeout_o));

    // R2: start clears the score and suppresses pulses
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (score_o == '0 && !match_o && !timeout_o));

    // R4: only the unpadded positions can count
    a_r4_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(score_o) <= SCORED_W);

    // R5: a match always carries a score at or above the threshold it was judged by
    a_r5_match_meets_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (int'(score_o) >= int'($past(thresh_i))));

    // R8: a pulse ends the search
    a_r8_pulse_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o || timeout_o) |-> !active_q);

    // R8: an idle block stays quiet until restarted
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !start_i) |=> ($stable(score_o) && !match_o && !timeout_o));
endmodule

bind dsss_sync_matcher sync_matcher_chk #(
    .SCORE_W (SCORE_W),
    .THR_W   (THR_W),
    .SCORED_W(WIN_W - PAD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .thresh_i (thresh_i),
    .match_o  (match_o),
    .timeout_o(timeout_o),
    .score_o  (score_o),
    .active_q (st_q.active)
);

// File: tb/tb_dsss_sync_matcher.sv
module tb_dsss_sync_matcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       bit_i = 1'b0;
    logic [7:0] thresh_i = 8'd60;
    logic [7:0] tmo_i = 8'd0;
    logic       match_o, timeout_o;
    logic [5:0] score_o;

    // R3 target, bit 0 newest, literal oldest first
    localparam logic [59:0] TGT =
        60'b1110_11101100_11101000_10100100_11111001_10010101_10001100_00100101;

    int tests = 0;
    int fails = 0;
    string phase = "R1";
    int n_match = 0;
    int n_tmo = 0;

    // reference model state
    bit q[$];
    bit m_active = 0;
    int m_cnt = 0;
    int m_score = 0;
    bit m_match = 0;
    bit m_tmo = 0;

    always #4 clk = ~clk;

    dsss_sync_matcher dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .thresh_i(thresh_i), .tmo_i(tmo_i),
        .match_o(match_o), .timeout_o(timeout_o), .score_o(score_o)
    );

    function automatic int ref_score();
        int s = 0;
        for (int k = 0; k < 48; k++) begin
            bit hb = (k < q.size()) ? q[k] : 1'b0;
            if (hb == TGT[k]) s++;
        end
        return s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete(); m_active = 0; m_cnt = 0; m_score = 0; m_match = 0; m_tmo = 0;
        end else begin
            m_match = 0;
            m_tmo = 0;
            if (start_i) begin
                q.delete(); m_cnt = 0; m_score = 0; m_active = 1;
            end else if (m_active && bit_vld_i) begin
                q.push_front(bit_i);
                if (q.size() > 60) void'(q.pop_back());
                m_cnt++;
                m_score = ref_score();
                if (m_score >= int'(thresh_i)) begin
                    m_match = 1; m_active = 0;
                end else if (tmo_i != 0 && m_cnt == int'(tmo_i) * 32) begin
                    m_tmo = 1; m_active = 0;
                end
            end
        end
    end

    task automatic compare();
        tests++;
        if (int'(score_o) != m_score) begin
            fails++;
            $display("FAIL %s score: got %0d exp %0d", phase, score_o, m_score);
        end
        tests++;
        if (match_o != m_match) begin
            fails++;
            $display("FAIL %s match: got %0b exp %0b", phase, match_o, m_match);
        end
        tests++;
        if (timeout_o != m_tmo) begin
            fails++;
            $display("FAIL %s timeout: got %0b exp %0b", phase, timeout_o, m_tmo);
        end
        if (m_match) n_match++;
        if (m_tmo) n_tmo++;
    endtask

    task automatic step(input bit st, input bit vld, input bit b);
        @(negedge clk);
        compare();
        start_i = st;
        bit_vld_i = vld;
        bit_i = b;
    endtask

    task automatic rand_bits(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 1'($urandom));
    endtask

    task automatic target_bits(input int newest_n);
        for (int j = 60 - newest_n; j < 60; j++) step(0, 1, TGT[59 - j]);
    endtask

    task automatic expect_count(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s pulse count: got %0d exp %0d", tag, got, exp);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got hung exp finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state, then bits before any start
        step(0, 0, 0);
        step(0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rand_bits(6);
        step(0, 0, 0);

        // R3 R4: long random search that cannot match or time out
        phase = "R3";
        thresh_i = 8'd60; tmo_i = 8'd0;
        step(1, 1, 1);
        rand_bits(30);
        phase = "R4";
        rand_bits(45);

        // R9: gaps in the valid strobe
        phase = "R9";
        for (int i = 0; i < 40; i++) step(0, 1'($urandom), 1'($urandom));

        // R5: full target after a random prefix, then R8 idle traffic
        phase = "R5";
        thresh_i = 8'd48;
        step(1, 0, 0);
        rand_bits(20);
        n_match = 0;
        target_bits(60);
        step(0, 0, 0);
        expect_count("R5", n_match, 1);
        phase = "R8";
        rand_bits(20);
        target_bits(60);
        step(0, 0, 0);
        expect_count("R8", n_match, 1);

        // R5: threshold zero matches on the first bit
        phase = "R5";
        thresh_i = 8'd0;
        step(1, 0, 0);
        n_match = 0;
        step(0, 1, 0);
        step(0, 0, 0);
        expect_count("R5", n_match, 1);

        // R6: limit of 64 bits
        phase = "R6";
        thresh_i = 8'd60; tmo_i = 8'd2;
        step(1, 0, 0);
        n_tmo = 0;
        rand_bits(70);
        expect_count("R6", n_tmo, 1);

        // R6: match and limit on the same bit, match wins
        thresh_i = 8'd48; tmo_i = 8'd2;
        step(1, 0, 0);
        n_tmo = 0; n_match = 0;
        rand_bits(16);
        target_bits(48);
        step(0, 0, 0);
        expect_count("R6", n_match, 1);
        expect_count("R6", n_tmo, 0);

        // R6: limit of 32 bits with gaps
        thresh_i = 8'd60; tmo_i = 8'd1;
        step(1, 0, 0);
        n_tmo = 0;
        for (int i = 0; i < 60; i++) step(0, 1'($urandom), 1'($urandom));
        rand_bits(40);
        expect_count("R6", n_tmo, 1);

        // R7: no limit when the timeout field is zero
        phase = "R7";
        tmo_i = 8'd0;
        step(1, 0, 0);
        n_tmo = 0;
        rand_bits(300);
        expect_count("R7", n_tmo, 0);

        // R2: restart mid-search with a bit offered on the start cycle
        phase = "R2";
        step(1, 1, 1);
        rand_bits(10);
        step(1, 1, 0);
        rand_bits(10);
        thresh_i = 8'd48;
        step(1, 1, 1);
        target_bits(60);
        step(0, 0, 0);
        step(0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule